// File: doc/BRIEF.md
# DRAM Impedance Calibration Scheduler

This block lives inside a DDR3-style memory controller and decides when each rank gets an impedance calibration command. There are two calibration lengths. The long one is owed by every rank after reset and again after each exit from self refresh. The short one is owed by every rank each time a periodic interval timer expires. A rank may be calibrated only when all of its banks are precharged and its precharge recovery time has elapsed. A rank that is not yet ready keeps its debt until it becomes ready.

The scheduler raises a request toward the main command arbiter and issues the command in the cycle that the arbiter grants it. It then holds a calibration window of a length set by a parameter. The first long calibration of each rank after reset uses an init-length window. Later long calibrations use an operational-length window, and short calibrations use a short window. During the window the scheduler marks the calibrating rank as blocked, keeps that rank's CKE high, disables ODT and keeps the DQ bus at high impedance. All ranks share one calibration resistor, so the scheduler never starts a window while another window is running.

Top module: `zq_cal_sched`

## Requirements
- R1: After reset, no request is raised and no window is active. Every rank owes a long calibration. The first long calibration of each rank uses the W_INIT window.
- R2: A rank is eligible only when it owes a calibration, its bit in `banks_idle_i` is 1 and its bit in `trp_met_i` is 1.
- R3: Among the eligible ranks, the lowest-numbered rank is chosen. If that rank owes a long calibration, the command is long (`cmd_long_o` = 1); otherwise it is short (0).
- R4: `cmd_valid_o` is high in exactly the cycle in which `req_o` and `gnt_i` are both high. `cmd_rank_o` and `cmd_long_o` describe the issued command in that same cycle.
- R5: `busy_o` rises in the cycle after an issue and stays high for exactly W_INIT cycles (first long calibration of the rank), W_LONG cycles (any later long calibration) or W_SHORT cycles (short calibration).
- R6: While a window is active, `req_o` and `cmd_valid_o` stay low. At most one rank is ever marked busy, so windows of ranks sharing the resistor never overlap.
- R7: A pulse on a rank's `sr_exit_i` bit makes that rank owe a long calibration. Issuing a long calibration also clears any short calibration the rank owes.
- R8: Every PERIOD cycles, the interval timer makes every rank owe a short calibration.
- R9: An owed calibration is never dropped. Without a grant, `req_o` stays high and no window starts.
- R10: During a window, `busy_rank_o` and `cke_hold_o` have the calibrating rank's bit set, and `odt_off_o` and `dq_hiz_o` are high. When no window is active, all four are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_exit_i | input | NRANK | One-cycle pulse per rank on self-refresh exit |
| banks_idle_i | input | NRANK | All banks of the rank are precharged |
| trp_met_i | input | NRANK | Precharge recovery time of the rank has elapsed |
| gnt_i | input | 1 | Grant from the main command arbiter |
| req_o | output | 1 | Calibration command wanted |
| cmd_valid_o | output | 1 | Calibration command issued this cycle |
| cmd_long_o | output | 1 | 1 = long calibration, 0 = short |
| cmd_rank_o | output | RW | Target rank of the command |
| busy_o | output | 1 | Calibration window active |
| busy_rank_o | output | NRANK | Rank that must receive no other command |
| cke_hold_o | output | NRANK | Force CKE high on this rank |
| odt_off_o | output | 1 | Force ODT disabled |
| dq_hiz_o | output | 1 | Keep the DQ bus at high impedance |

## Verification
The selection logic is tested with single self-refresh exits on each rank, with exits on both ranks at once, and with readiness masks that hold back one rank. Together these separate lowest-index priority from plain arrival order and show that an unready rank is skipped rather than dropped. The window lengths are measured on the first long calibration, a later long calibration and a short one, which distinguishes the three windows. A self-refresh exit that arrives while a short calibration is still owed shows whether the long command takes precedence over the short one and then clears it.

// File: rtl/zqs_pkg.sv
package zqs_pkg;

    typedef enum logic {
        ZQ_SHORT = 1'b0,
        ZQ_LONG  = 1'b1
    } zq_kind_e;

    typedef struct packed {
        logic     owe_long;
        logic     owe_short;
        logic     first_done;
    } rank_debt_t;

    function automatic int unsigned cnt_bits(input int unsigned maxval);
        return (maxval < 2) ? 1 : $clog2(maxval + 1);
    endfunction

endpackage

// File: rtl/zqs_interval_timer.sv
module zqs_interval_timer #(
    parameter int unsigned PERIOD = 8192
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int unsigned TW = zqs_pkg::cnt_bits(PERIOD);

    logic [TW-1:0] count_q;
    logic          at_end;

    assign at_end = (count_q == TW'(PERIOD - 1));
    assign tick_o = at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (at_end) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/zqs_rank_debt.sv
module zqs_rank_debt
    import zqs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sr_exit,
    input  logic       period_tick,
    input  logic       issue,
    input  zq_kind_e   issue_kind,
    output rank_debt_t debt_o
);
    rank_debt_t debt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            debt_q.owe_long   <= 1'b1;
            debt_q.owe_short  <= 1'b0;
            debt_q.first_done <= 1'b0;
        end else begin
            if (issue) begin
                debt_q.first_done <= 1'b1;
                debt_q.owe_long   <= 1'b0;
                debt_q.owe_short  <= 1'b0;
                if (issue_kind == ZQ_SHORT) begin
                    debt_q.owe_long <= debt_q.owe_long;
                end
            end
            if (sr_exit) begin
                debt_q.owe_long <= 1'b1;
            end
            if (period_tick) begin
                debt_q.owe_short <= 1'b1;
            end
        end
    end

    assign debt_o = debt_q;
endmodule

// File: rtl/zqs_window.sv
module zqs_window #(
    parameter int unsigned WMAX = 512
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               load,
    input  logic [zqs_pkg::cnt_bits(WMAX)-1:0] length,
    output logic                               active_o
);
    localparam int unsigned CW = zqs_pkg::cnt_bits(WMAX);

    logic [CW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= length;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign active_o = (left_q != '0);
endmodule

// File: rtl/zq_cal_sched.sv
module zq_cal_sched
    import zqs_pkg::*;
#(
    parameter int unsigned NRANK   = 2,
    parameter int unsigned W_INIT  = 512,
    parameter int unsigned W_LONG  = 256,
    parameter int unsigned W_SHORT = 64,
    parameter int unsigned PERIOD  = 8192,
    localparam int unsigned RW     = (NRANK > 1) ? $clog2(NRANK) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NRANK-1:0] sr_exit_i,
    input  logic [NRANK-1:0] banks_idle_i,
    input  logic [NRANK-1:0] trp_met_i,
    input  logic             gnt_i,
    output logic             req_o,
    output logic             cmd_valid_o,
    output logic             cmd_long_o,
    output logic [RW-1:0]    cmd_rank_o,
    output logic             busy_o,
    output logic [NRANK-1:0] busy_rank_o,
    output logic [NRANK-1:0] cke_hold_o,
    output logic             odt_off_o,
    output logic             dq_hiz_o
);
    localparam int unsigned WMAX_A = (W_INIT > W_LONG) ? W_INIT : W_LONG;
    localparam int unsigned WMAX   = (WMAX_A > W_SHORT) ? WMAX_A : W_SHORT;
    localparam int unsigned CW     = cnt_bits(WMAX);

    logic             tick;
    rank_debt_t       debt [NRANK];
    logic [NRANK-1:0] eligible;
    logic [NRANK-1:0] issue_vec;
    logic [RW-1:0]    sel_rank;
    logic             sel_found;
    zq_kind_e         sel_kind;
    logic [CW-1:0]    sel_len;
    logic [RW-1:0]    act_rank_q;
    logic             win_active;
    logic             fire;

    zqs_interval_timer #(.PERIOD(PERIOD)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick)
    );

    for (genvar r = 0; r < NRANK; r++) begin : g_rank
        zqs_rank_debt u_debt (
            .clk         (clk),
            .rst         (rst),
            .sr_exit     (sr_exit_i[r]),
            .period_tick (tick),
            .issue       (issue_vec[r]),
            .issue_kind  (sel_kind),
            .debt_o      (debt[r])
        );
        assign eligible[r] = (debt[r].owe_long | debt[r].owe_short)
                             & banks_idle_i[r] & trp_met_i[r];
        assign issue_vec[r] = fire && (sel_rank == RW'(r));
    end

    always_comb begin
        sel_rank  = '0;
        sel_found = 1'b0;
        for (int r = NRANK - 1; r >= 0; r--) begin
            if (eligible[r]) begin
                sel_rank  = RW'(r);
                sel_found = 1'b1;
            end
        end
    end

    always_comb begin
        sel_kind = ZQ_SHORT;
        sel_len  = CW'(W_SHORT);
        for (int r = 0; r < NRANK; r++) begin
            if (sel_rank == RW'(r) && debt[r].owe_long) begin
                sel_kind = ZQ_LONG;
                sel_len  = debt[r].first_done ? CW'(W_LONG) : CW'(W_INIT);
            end
        end
    end

    zqs_window #(.WMAX(WMAX)) u_window (
        .clk      (clk),
        .rst      (rst),
        .load     (fire),
        .length   (sel_len),
        .active_o (win_active)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            act_rank_q <= '0;
        end else if (fire) begin
            act_rank_q <= sel_rank;
        end
    end

    assign req_o       = sel_found && !win_active;
    assign fire        = req_o && gnt_i;
    assign cmd_valid_o = fire;
    assign cmd_long_o  = (sel_kind == ZQ_LONG);
    assign cmd_rank_o  = sel_rank;
    assign busy_o      = win_active;
    assign odt_off_o   = win_active;
    assign dq_hiz_o    = win_active;

    always_comb begin
        busy_rank_o = '0;
        for (int r = 0; r < NRANK; r++) begin
            busy_rank_o[r] = win_active && (act_rank_q == RW'(r));
        end
    end

    assign cke_hold_o = busy_rank_o;
endmodule

// File: rtl/zqs_checker.sv
module zqs_checker #(
    parameter int unsigned NRANK = 2,
    parameter int unsigned RW    = 1
) (
    input logic             clk,
    input logic             rst,
    input logic [NRANK-1:0] banks_idle_i,
    input logic [NRANK-1:0] trp_met_i,
    input logic             gnt_i,
    input logic             req_o,
    input logic             cmd_valid_o,
    input logic [RW-1:0]    cmd_rank_o,
    input logic             busy_o,
    input logic [NRANK-1:0] busy_rank_o,
    input logic [NRANK-1:0] cke_hold_o,
    input logic             odt_off_o,
    input logic             dq_hiz_o
);
    assert_ready_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |-> (banks_idle_i[cmd_rank_o] && trp_met_i[cmd_rank_o]));

    assert_handshake_R4: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |-> (req_o && gnt_i));

    assert_window_start_R5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |=> busy_o);

    assert_no_issue_busy_R6: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (!req_o && !cmd_valid_o));

    assert_single_rank_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(busy_rank_o));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (req_o && !gnt_i && !busy_o) |=> !busy_o);

    assert_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (odt_off_o && dq_hiz_o && $countones(cke_hold_o) == 1));

    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!odt_off_o && !dq_hiz_o && cke_hold_o == '0));
endmodule

bind zq_cal_sched zqs_checker #(.NRANK(NRANK), .RW(RW)) u_zqs_checker (
    .clk          (clk),
    .rst          (rst),
    .banks_idle_i (banks_idle_i),
    .trp_met_i    (trp_met_i),
    .gnt_i        (gnt_i),
    .req_o        (req_o),
    .cmd_valid_o  (cmd_valid_o),
    .cmd_rank_o   (cmd_rank_o),
    .busy_o       (busy_o),
    .busy_rank_o  (busy_rank_o),
    .cke_hold_o   (cke_hold_o),
    .odt_off_o    (odt_off_o),
    .dq_hiz_o     (dq_hiz_o)
);

// File: tb/tb_zq_cal_sched.sv
module tb_zq_cal_sched;
    localparam int NR = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NR-1:0] sr_exit = '0;
    logic [NR-1:0] idle = '0;
    logic [NR-1:0] trp = '0;
    logic          gnt = 1'b0;
    logic          req, cval, clong, busy, odt, dqz;
    logic [0:0]    crank;
    logic [NR-1:0] brank, cke;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    zq_cal_sched #(
        .NRANK(NR), .W_INIT(8), .W_LONG(6), .W_SHORT(3), .PERIOD(300)
    ) dut (
        .clk(clk), .rst(rst), .sr_exit_i(sr_exit), .banks_idle_i(idle),
        .trp_met_i(trp), .gnt_i(gnt), .req_o(req), .cmd_valid_o(cval),
        .cmd_long_o(clong), .cmd_rank_o(crank), .busy_o(busy),
        .busy_rank_o(brank), .cke_hold_o(cke), .odt_off_o(odt), .dq_hiz_o(dqz)
    );

    // table entry: {sr_exit[1:0], exp_rank, exp_long, exp_window[3:0]}
    localparam logic [7:0] VEC [4] = '{
        {2'b01, 1'b0, 1'b1, 4'd6},
        {2'b10, 1'b1, 1'b1, 4'd6},
        {2'b11, 1'b0, 1'b1, 4'd6},
        {2'b00, 1'b1, 1'b1, 4'd6}
    };

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic do_issue(input int er, input int el, input int ew, input string tag);
        int n;
        @(negedge clk);
        chk(req === 1'b1, tag, "req before grant", int'(req), 1);
        chk(int'(crank) == er, "R3", "selected rank", int'(crank), er);
        chk(int'(clong) == el, "R3", "command kind", int'(clong), el);
        gnt = 1'b1;
        #1;
        chk(cval === 1'b1, "R4", "cmd_valid with grant", int'(cval), 1);
        @(negedge clk);
        gnt = 1'b0;
        n = 0;
        while (busy === 1'b1 && n < 1000) begin
            chk(req === 1'b0 && cval === 1'b0, "R6", "quiet while busy", int'(req), 0);
            chk(cke == NR'(1 << er) && brank == NR'(1 << er) && odt && dqz,
                "R10", "window controls", int'(cke), 1 << er);
            n++;
            @(negedge clk);
        end
        chk(n == ew, "R5", "window length", n, ew);
        chk(cke == '0 && brank == '0 && !odt && !dqz, "R10", "idle controls",
            int'(cke), 0);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(req === 1'b0 && busy === 1'b0, "R1", "reset req/busy", int'(req), 0);
        chk(cke == '0 && !odt && !dqz, "R1", "reset controls", int'(cke), 0);

        // R2: banks idle but recovery not met
        idle = 2'b11;
        @(negedge clk);
        chk(req === 1'b0, "R2", "trp not met holds request", int'(req), 0);
        trp = 2'b10;
        @(negedge clk);
        chk(req === 1'b1 && crank == 1'b1, "R2", "only ready rank requests",
            int'(crank), 1);

        // R1: first long calibration per rank uses init window
        do_issue(1, 1, 8, "R1");
        trp = 2'b11;
        do_issue(0, 1, 8, "R1");
        @(negedge clk);
        chk(req === 1'b0, "R1", "no debt left after init", int'(req), 0);

        // R7 table: self-refresh exits
        for (int i = 0; i < 4; i++) begin
            sr_exit = VEC[i][7:6];
            @(negedge clk);
            sr_exit = '0;
            do_issue(int'(VEC[i][5]), int'(VEC[i][4]), int'(VEC[i][3:0]), "R7");
        end

        // R8: periodic short debt appears by itself
        begin
            int w = 0;
            while (req !== 1'b1 && w < 1000) begin
                @(negedge clk);
                w++;
            end
            chk(req === 1'b1 && clong == 1'b0 && crank == 1'b0, "R8",
                "periodic short request", int'(clong), 0);
        end

        // R9: no grant, request persists
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(req === 1'b1 && busy === 1'b0, "R9", "request held", int'(req), 1);
        end

        // R2: rank 0 not precharged -> rank 1 selected
        idle = 2'b10;
        @(negedge clk);
        chk(req === 1'b1 && crank == 1'b1 && clong == 1'b0, "R2",
            "unready rank skipped", int'(crank), 1);
        idle = 2'b11;

        // R7: long debt overrides owed short, then clears it
        sr_exit = 2'b01;
        @(negedge clk);
        sr_exit = '0;
        do_issue(0, 1, 6, "R7");
        do_issue(1, 0, 3, "R5");
        repeat (3) begin
            @(negedge clk);
            chk(req === 1'b0, "R7", "short cleared by long", int'(req), 0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule